// File: doc/BRIEF.md
# Rectangular Region Fetch Command Generator

This block turns a request for a rectangle of reference luma pixels into the command stream an external memory controller expects. The frame sits in memory in raster order, one luma byte per pixel and four pixels per 32-bit word. A request gives the top-left pixel column and row, the width and height in pixels, the frame base address and the frame line pitch in pixels. The block registers the request and computes the word-aligned geometry. It then writes four command words into the controller's command FIFO. A full flag pauses that write and it resumes without losing its place.

While the commands go out, the block also pulls returned words from the controller's read-data FIFO and counts them. When the count reaches the number of words in the rectangle, it raises a one-cycle completion pulse. Returned words pass straight through to the consumer, which handles unpacking and caching. A new request is taken only once the previous one has written all its command words and received all its data.

Top module: `rgn_fetch_gen`

## Requirements
- R1: Each accepted request produces exactly four command words, in this order: X size, start address, Y size, line pitch. The first word can be written in the cycle after acceptance.
- R2: The X size word equals ((x mod 4) + w + 3) / 4, with integer division. This is the number of 32-bit words covering columns x to x+w-1 once x is aligned down to a multiple of 4. The word is zero-extended to 32 bits.
- R3: The address word equals (base + floor((y * pitch + x_aligned) / 4)) modulo 2^30, with bits 31:30 zero.
- R4: The Y size word equals h and the pitch word equals pitch, both zero-extended to 32 bits.
- R5: `cmd_we` is never high while `cmd_full` is high. During a stall, `cmd_data` holds the pending word, and the sequence resumes at that word without skipping or repeating any word.
- R6: `rd_re` is high only while `rd_empty` is low and data words are still owed. `rd_word` equals `rd_data`, and `rd_word_valid` equals `rd_re`.
- R7: `region_done` is a single-cycle pulse in the cycle after the read that completes X size × h words. No further reads follow for that request. When X size × h is zero, the pulse comes in the cycle after acceptance and no reads occur.
- R8: `req_ready` is high only when no command word and no data word is outstanding. A request presented while `req_ready` is low has no effect on the command words or the read count.
- R9: During and right after reset, `req_ready` is 1 and `cmd_we`, `rd_re` and `region_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Region request present |
| req_ready | output | 1 | Block can take a request |
| req_x | input | COORD_W | Left pixel column |
| req_y | input | COORD_W | Top pixel row |
| req_w | input | COORD_W | Width in pixels |
| req_h | input | COORD_W | Height in rows |
| frame_base | input | ADDR_W | Word address of the frame start |
| line_pitch | input | COORD_W | Pixels per frame line |
| cmd_data | output | 32 | Command word |
| cmd_we | output | 1 | Command word write enable |
| cmd_full | input | 1 | Command FIFO full |
| rd_data | input | 32 | Returned data word |
| rd_empty | input | 1 | Read-data FIFO empty |
| rd_re | output | 1 | Read-data FIFO read enable |
| rd_word | output | 32 | Returned word passed to the consumer |
| rd_word_valid | output | 1 | `rd_word` is valid this cycle |
| region_done | output | 1 | All words of the region received |

## Verification
The bench builds the block with its defaults: 12-bit coordinates, a 30-bit address and four pixels per word. At these widths the bench can drive a base address near the top of the address space, so the address sum wraps. The widest pitch and row values stay inside the linear offset, and every column phase within a word can be tried, including widths of zero and one. The bench also stalls the command FIFO for long runs and starves the data FIFO at random, so the pause-and-resume path and the final-read timing are exercised under heavy back-pressure.

// File: rtl/rfg_pkg.sv
// Shared constants and the command word slot order for the region fetch block.
package rfg_pkg;
    localparam int unsigned CMD_W     = 32;
    localparam int unsigned CMD_WORDS = 4;

    // Slot order is what the memory controller decodes; it must not change.
    typedef enum logic [1:0] {
        SLOT_XSIZE = 2'd0,
        SLOT_ADDR  = 2'd1,
        SLOT_YSIZE = 2'd2,
        SLOT_PITCH = 2'd3
    } slot_e;
endpackage

// File: rtl/rfg_geom.sv
// Region geometry: aligns the left edge to a word and counts the words per row.
// It also forms the start word address and the total word count. The command
// words are registered on load. The total is combinational so that the read
// counter can load it in the same cycle.
// Assumes PIX_PER_WORD is a power of two of at least 2 and that
// COORD_W + 1 <= 32.
module rfg_geom
    import rfg_pkg::*;
#(
    parameter int unsigned COORD_W      = 12,
    parameter int unsigned ADDR_W       = 30,
    parameter int unsigned PIX_PER_WORD = 4,
    localparam int unsigned SHIFT       = $clog2(PIX_PER_WORD),
    localparam int unsigned XW_W        = COORD_W + 1,
    localparam int unsigned LIN_W       = 2 * COORD_W + 1,
    localparam int unsigned CNT_W       = XW_W + COORD_W
)(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               load,
    input  logic [COORD_W-1:0]                 x,
    input  logic [COORD_W-1:0]                 y,
    input  logic [COORD_W-1:0]                 w,
    input  logic [COORD_W-1:0]                 h,
    input  logic [ADDR_W-1:0]                  base,
    input  logic [COORD_W-1:0]                 pitch,
    output logic [CNT_W-1:0]                   total,
    output logic [CMD_WORDS-1:0][CMD_W-1:0]    words
);
    localparam logic [COORD_W-1:0] SUB_MASK = COORD_W'(PIX_PER_WORD - 1);

    logic [COORD_W-1:0] x_al;
    logic [COORD_W+1:0] span;
    logic [XW_W-1:0]    x_words;
    logic [LIN_W-1:0]   lin;
    logic [LIN_W-1:0]   word_off;
    logic [ADDR_W-1:0]  start_addr;

    // Word-aligned geometry derived from the request fields.
    always_comb begin
        x_al       = x & ~SUB_MASK;
        span       = (COORD_W+2)'(x & SUB_MASK) + (COORD_W+2)'(w) + (COORD_W+2)'(PIX_PER_WORD - 1);
        x_words    = XW_W'(span >> SHIFT);
        lin        = LIN_W'(y) * LIN_W'(pitch) + LIN_W'(x_al);
        word_off   = lin >> SHIFT;
        start_addr = base + ADDR_W'(word_off);
        total      = CNT_W'(x_words) * CNT_W'(h);
    end

    // Capture the four command words when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (load) begin
            words[SLOT_XSIZE] <= CMD_W'(x_words);
            words[SLOT_ADDR]  <= CMD_W'(start_addr);
            words[SLOT_YSIZE] <= CMD_W'(h);
            words[SLOT_PITCH] <= CMD_W'(pitch);
        end
    end
endmodule

// File: rtl/rfg_cmd_seq.sv
// Command sequencer: writes the four registered words in slot order.
// It holds the current slot while the FIFO reports full. Assumes start is
// never raised while busy.
module rfg_cmd_seq
    import rfg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [CMD_WORDS-1:0][CMD_W-1:0]  words,
    input  logic                             cmd_full,
    output logic                             cmd_we,
    output logic [CMD_W-1:0]                 cmd_data,
    output logic                             busy
);
    logic [1:0] slot;
    logic       active;

    // Write enable waits for room; data is the word at the current slot.
    always_comb begin
        cmd_we   = active && !cmd_full;
        cmd_data = words[slot];
        busy     = active;
    end

    // Advance one slot per accepted write and stop after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            slot   <= 2'd0;
        end else if (start) begin
            active <= 1'b1;
            slot   <= 2'd0;
        end else if (cmd_we) begin
            if (slot == 2'(CMD_WORDS - 1)) begin
                active <= 1'b0;
            end
            slot <= slot + 2'd1;
        end
    end
endmodule

// File: rtl/rfg_rd_count.sv
// Read counter: pulls returned words while data is owed, then pulses done
// after the final read. A zero-size region pulses done at once.
// Assumes start is never raised while busy.
module rfg_rd_count #(
    parameter int unsigned CNT_W = 25
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             rd_empty,
    output logic             rd_re,
    output logic             done,
    output logic             busy
);
    logic [CNT_W-1:0] remain;
    logic             active;

    // Read whenever words are owed and the FIFO has one.
    always_comb begin
        rd_re = active && !rd_empty;
        busy  = active;
    end

    // Load the word count, count it down, and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                remain <= total;
                active <= (total != '0);
                done   <= (total == '0);
            end else if (rd_re) begin
                remain <= remain - 1'b1;
                if (remain == CNT_W'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rgn_fetch_gen.sv
// Top level: takes a rectangle request when idle, issues its four-word
// memory command and counts the returned data words to completion.
// Assumes the memory controller returns exactly the words of the rectangle.
module rgn_fetch_gen
    import rfg_pkg::*;
#(
    parameter int unsigned COORD_W      = 12,
    parameter int unsigned ADDR_W       = 30,
    parameter int unsigned PIX_PER_WORD = 4,
    localparam int unsigned CNT_W       = 2 * COORD_W + 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [COORD_W-1:0] req_w,
    input  logic [COORD_W-1:0] req_h,
    input  logic [ADDR_W-1:0]  frame_base,
    input  logic [COORD_W-1:0] line_pitch,
    output logic [CMD_W-1:0]   cmd_data,
    output logic               cmd_we,
    input  logic               cmd_full,
    input  logic [CMD_W-1:0]   rd_data,
    input  logic               rd_empty,
    output logic               rd_re,
    output logic [CMD_W-1:0]   rd_word,
    output logic               rd_word_valid,
    output logic               region_done
);
    logic                            accept;
    logic                            seq_busy;
    logic                            rd_busy;
    logic [CNT_W-1:0]                total;
    logic [CMD_WORDS-1:0][CMD_W-1:0] words;

    // Idle only when both the command and data sides have finished.
    always_comb begin
        req_ready     = !seq_busy && !rd_busy;
        accept        = req_valid && req_ready;
        rd_word       = rd_data;
        rd_word_valid = rd_re;
    end

    rfg_geom #(
        .COORD_W      (COORD_W),
        .ADDR_W       (ADDR_W),
        .PIX_PER_WORD (PIX_PER_WORD)
    ) u_geom (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .x     (req_x),
        .y     (req_y),
        .w     (req_w),
        .h     (req_h),
        .base  (frame_base),
        .pitch (line_pitch),
        .total (total),
        .words (words)
    );

    rfg_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .words    (words),
        .cmd_full (cmd_full),
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .busy     (seq_busy)
    );

    rfg_rd_count #(
        .CNT_W (CNT_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .total    (total),
        .rd_empty (rd_empty),
        .rd_re    (rd_re),
        .done     (region_done),
        .busy     (rd_busy)
    );
endmodule

// File: rtl/rfg_checker.sv
// Protocol checks for the region fetch block, bound to its top level.
module rfg_checker
    import rfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic             cmd_full,
    input logic [CMD_W-1:0] cmd_data,
    input logic             rd_re,
    input logic             rd_empty,
    input logic             region_done,
    input logic             req_ready,
    input logic             seq_busy
);
    AST_WE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n) cmd_we |-> !cmd_full); // R5
    AST_STALL_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n) (seq_busy && cmd_full) |=> $stable(cmd_data)); // R5
    AST_RE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) rd_re |-> !rd_empty); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) region_done |=> !region_done); // R7
    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n) seq_busy |-> !req_ready); // R8
endmodule

bind rgn_fetch_gen rfg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_full    (cmd_full),
    .cmd_data    (cmd_data),
    .rd_re       (rd_re),
    .rd_empty    (rd_empty),
    .region_done (region_done),
    .req_ready   (req_ready),
    .seq_busy    (seq_busy)
);

// File: tb/rgn_fetch_gen_bench.sv
`timescale 1ns/1ps
// Bench: random and directed region requests under random FIFO back-pressure.
module rgn_fetch_gen_bench;
    localparam int COORD_W = 12;
    localparam int ADDR_W  = 30;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid;
    logic               req_ready;
    logic [COORD_W-1:0] req_x, req_y, req_w, req_h, line_pitch;
    logic [ADDR_W-1:0]  frame_base;
    logic [31:0]        cmd_data;
    logic               cmd_we;
    logic               cmd_full;
    logic [31:0]        rd_data;
    logic               rd_empty;
    logic               rd_re;
    logic [31:0]        rd_word;
    logic               rd_word_valid;
    logic               region_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rgn_fetch_gen u_rgn_fetch_gen (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_x (req_x), .req_y (req_y), .req_w (req_w), .req_h (req_h),
        .frame_base (frame_base), .line_pitch (line_pitch),
        .cmd_data (cmd_data), .cmd_we (cmd_we), .cmd_full (cmd_full),
        .rd_data (rd_data), .rd_empty (rd_empty), .rd_re (rd_re),
        .rd_word (rd_word), .rd_word_valid (rd_word_valid),
        .region_done (region_done)
    );

    // Words per row after aligning the left edge down (R2).
    function automatic longint exp_xw(input longint x, input longint w);
        return ((x % 4) + w + 3) / 4;
    endfunction

    // Start word address with wrap in the 30-bit space (R3).
    function automatic longint exp_addr(input longint x, input longint y,
                                        input longint base, input longint pitch);
        return (base + ((y * pitch + (x - (x % 4))) / 4)) % (64'd1 << 30);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Runs one request end to end; full_pct and empty_pct set back-pressure.
    task automatic run_req(input int x, input int y, input int w, input int h,
                           input longint base, input int pitch,
                           input int full_pct, input int empty_pct);
        longint exp_w [4];
        longint total;
        int wc = 0, rc = 0, done_cnt = 0, last_rd = -10, cyc = 0, tail = 0;
        bit accepted = 0;
        exp_w[0] = exp_xw(x, w);
        exp_w[1] = exp_addr(x, y, base, pitch);
        exp_w[2] = h;
        exp_w[3] = pitch;
        total = exp_w[0] * h;
        @(negedge clk);
        req_x = COORD_W'(x); req_y = COORD_W'(y); req_w = COORD_W'(w);
        req_h = COORD_W'(h); frame_base = ADDR_W'(base); line_pitch = COORD_W'(pitch);
        req_valid = 1'b1;
        while (tail < 3 && cyc < 20000) begin
            cmd_full = ($urandom_range(99) < full_pct);
            rd_empty = (done_cnt > 0) ? 1'b0 : ($urandom_range(99) < empty_pct);
            rd_data  = $urandom;
            if (accepted && wc < 4) begin
                // R8: requests while busy must be ignored.
                req_valid = 1'b1;
                req_x = COORD_W'($urandom); req_y = COORD_W'($urandom);
                req_w = COORD_W'($urandom); req_h = COORD_W'($urandom);
                frame_base = ADDR_W'($urandom); line_pitch = COORD_W'($urandom);
            end else if (accepted) begin
                req_valid = 1'b0;
            end
            #1;
            if (!accepted && req_valid && req_ready) accepted = 1;
            if (cmd_we) begin
                check(!cmd_full, "R5 write while full", 1, 0);
                if (wc < 4) begin
                    case (wc)
                        0: check(cmd_data == 32'(exp_w[0]), "R1/R2 xsize word", cmd_data, exp_w[0]);
                        1: check(cmd_data == 32'(exp_w[1]), "R1/R3 address word", cmd_data, exp_w[1]);
                        2: check(cmd_data == 32'(exp_w[2]), "R1/R4 ysize word", cmd_data, exp_w[2]);
                        default: check(cmd_data == 32'(exp_w[3]), "R1/R4 pitch word", cmd_data, exp_w[3]);
                    endcase
                end else begin
                    check(0, "R1 extra command word", wc + 1, 4);
                end
                wc++;
            end
            if (rd_re) begin
                check(!rd_empty && rd_word_valid && rd_word == rd_data, "R6 read handshake", rd_word, rd_data);
                rc++;
                last_rd = cyc;
            end
            if (region_done) begin
                done_cnt++;
                check(rc == total, "R7 reads at done", rc, total);
                if (total != 0) check(last_rd == cyc - 1, "R7 done timing", last_rd, cyc - 1);
            end
            if (done_cnt > 0 && wc >= 4) tail++;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(wc == 4, "R1 word count", wc, 4);
        check(done_cnt == 1, "R7 done pulses", done_cnt, 1);
        check(rc == total, "R6 total reads", rc, total);
        check(req_ready == 1'b1, "R8 ready after region", req_ready, 1);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        rst_n = 1'b0; req_valid = 1'b0; cmd_full = 1'b0; rd_empty = 1'b0;
        rd_data = '0; req_x = '0; req_y = '0; req_w = '0; req_h = '0;
        frame_base = '0; line_pitch = '0;
        repeat (3) @(negedge clk);
        #1;
        check(req_ready && !cmd_we && !rd_re && !region_done, "R9 reset state", {req_ready, cmd_we, rd_re, region_done}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(req_ready && !cmd_we && !rd_re && !region_done, "R9 after reset", {req_ready, cmd_we, rd_re, region_done}, 4'b1000);

        // Directed corner cases.
        run_req(3, 2, 1, 2, 30'h100, 64, 0, 0);          // R2 single-pixel at last column phase
        run_req(3, 5, 2, 3, 30'h200, 128, 20, 20);       // R2 straddles a word boundary
        run_req(8, 1, 0, 5, 30'h40, 32, 0, 0);           // R7 zero width gives no reads
        run_req(5, 1, 7, 0, 30'h40, 32, 0, 0);           // R7 zero height
        run_req(2, 4095, 9, 2, 30'h3FFF_FFF0, 4095, 10, 10); // R3 address wrap, large pitch
        run_req(0, 0, 16, 4, 30'h0, 320, 90, 0);         // R5 long command stalls
        run_req(1, 7, 11, 6, 30'h1234, 720, 0, 85);      // R6 starved data FIFO

        // Random requests.
        for (int i = 0; i < 40; i++) begin
            run_req($urandom_range(4095), $urandom_range(4095), $urandom_range(40),
                    $urandom_range(8), longint'($urandom_range(32'h3FFF_FFFF)),
                    $urandom_range(4095), $urandom_range(70), $urandom_range(70));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule